// File: doc/BRIEF.md
# CompactFlash Multiword DMA Engine

This block moves one contiguous buffer of 16-bit words between a local memory port and a CompactFlash card, using the multiword DMA request and acknowledge handshake. Before a transfer, the host side writes a start address, a word count, a direction and a few mode bits in one configuration write. Strobe timing comes from static inputs. For each word the engine raises the acknowledge, waits a setup time, pulses the read or write strobe for an active time, then keeps it negated for a recovery time. After the last word it holds the acknowledge for a hold time, drops it, clears its busy flag and sets a sticky completion flag. That flag can drive an interrupt line.

The word count uses minus-one form and counts down to all-ones as words complete, so the host can read it back to see how much of the transfer is done. If the card drops its request in the middle of a transfer, the engine either waits for the request to return or ends the transfer, depending on a mode bit. A byte-lane exchange can be applied to every word in both directions.

Top module: `cf_mwdma_engine`

## Requirements
- R1: After reset, `busy`, `done` and `irq` are 0, both strobes (`dior_n`, `diow_n`) are 1, `dmack` is at its inactive level, and `size_rb` reads all-ones (0xFFFFF).
- R2: The size is loaded from `cfg_size` as word count minus one. It drops by exactly 1 per completed word, so a value S moves S+1 words and `size_rb` reads 0xFFFFF after a full transfer.
- R3: When the last word and its acknowledge hold are finished, `busy` goes to 0 and `done` goes to 1. A pulse on `done_clr` clears `done`. If completion and `done_clr` fall in the same cycle, `done` ends up set.
- R4: `irq` is 1 exactly when `done` is 1 and `irq_en` is 1.
- R5: With `cfg_to_dev`=1, each word is read from memory (`mem_rd`) and driven on `dd_out` with `dd_oe`=1 under a `diow_n` pulse. With `cfg_to_dev`=0, each word is taken from `dd_in` at the end of a `dior_n` pulse and written to memory (`mem_wr`). The two strobes are never low together.
- R6: `mem_addr` starts at `cfg_addr` and advances by 2 after every word.
- R7: With `cfg_swap`=1, bits [15:8] and [7:0] of every word trade places, in both directions.
- R8: With `cfg_stop_on_drop`=0, if `dmarq` is low when a word's recovery time ends, the engine holds and releases `dmack`, stays busy and issues no strobe until `dmarq` is back. It then moves the remaining words.
- R9: With `cfg_stop_on_drop`=1, the same drop ends the transfer after the hold time: `busy` goes to 0, `done` goes to 1, and `size_rb` keeps the count of words not moved, in minus-one form.
- R10: Each phase (acknowledge setup, active strobe, negated strobe, acknowledge hold, pause) lasts its field times the multiplier chosen by `tim_mult`: 0 = x4, 1 = x1, 2 = x2, 3 = x8. A product of zero gives one cycle.
- R11: `dmack` is asserted only after `dmarq` has been high for `rq_qual`+1 consecutive clock cycles. This count is in raw clocks and ignores `tim_mult`.
- R12: `dmack` is active-high when `ack_pol`=1 and active-low when `ack_pol`=0. Every strobe pulse happens while `dmack` is active.
- R13: A configuration write with `cfg_en`=0 and `cfg_size`=0xFFFFF stops the engine by the next cycle: `busy` is 0, strobes are high, `dmack` is inactive, `done` is unchanged and `size_rb` reads 0xFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable bit to load |
| cfg_to_dev | input | 1 | 1 = memory to card, 0 = card to memory |
| cfg_stop_on_drop | input | 1 | 1 = a request drop ends the transfer |
| cfg_swap | input | 1 | 1 = exchange the bytes of every word |
| cfg_size | input | SW (20) | Word count minus one |
| cfg_addr | input | AW (32) | Start byte address |
| done_clr | input | 1 | Write-one-to-clear for `done` |
| irq_en | input | 1 | Interrupt enable |
| tim_mult | input | 2 | Timing multiplier code |
| rd_act | input | TW (6) | Read strobe active time |
| rd_neg | input | TW (6) | Read strobe negated time |
| wr_act | input | TW (6) | Write strobe active time |
| wr_neg | input | TW (6) | Write strobe negated time |
| ack_setup | input | TW (6) | Acknowledge-to-strobe setup |
| ack_hold | input | TW (6) | Acknowledge hold after the last strobe |
| pause_len | input | TW (6) | Gap after a hold before re-qualifying |
| rq_qual | input | QW (4) | Request qualification, raw clocks |
| ack_pol | input | 1 | Acknowledge polarity, 1 = active-high |
| busy | output | 1 | Enable bit readback |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Gated completion interrupt |
| size_rb | output | SW (20) | Remaining size, minus-one form |
| mem_rd | output | 1 | Memory read strobe, data expected the same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW (32) | Memory byte address |
| mem_wdata | output | DW (16) | Memory write data |
| mem_rdata | input | DW (16) | Memory read data |
| dmarq | input | 1 | DMA request from the card |
| dmack | output | 1 | DMA acknowledge to the card |
| dior_n | output | 1 | Read strobe, active-low |
| diow_n | output | 1 | Write strobe, active-low |
| dd_out | output | DW (16) | Data toward the card |
| dd_oe | output | 1 | Output enable for `dd_out` |
| dd_in | input | DW (16) | Data from the card |

## Verification
Two events can land on the same clock edge: the engine setting the completion flag at the end of its final acknowledge hold, and a write-one-to-clear of that flag. The bench sees the last write strobe rise. It then counts the recovery and hold cycles it knows from the programmed fields and raises `done_clr` on exactly the edge where the hold ends. It checks that `done` was 0 just before that edge and is 1 just after it. A second pair of events is a request drop while a word is in flight. The bench drops `dmarq` during the second strobe and judges the outcome by the number of strobes seen and the size read back, once in the pause mode and once in the terminate mode.

// File: rtl/cfmw_pkg.sv
package cfmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUAL,
    ST_SETUP,
    ST_ACT,
    ST_NEG,
    ST_HOLD,
    ST_PAUSE
  } cfmw_state_e;

  // timing multiplier code: 0 -> x4, 1 -> x1, 2 -> x2, 3 -> x8
  function automatic logic [3:0] mult_of(input logic [1:0] code);
    case (code)
      2'd0:    mult_of = 4'd4;
      2'd1:    mult_of = 4'd1;
      2'd2:    mult_of = 4'd2;
      default: mult_of = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/cfmw_phase_timer.sv
module cfmw_phase_timer #(
  parameter int TW = 6,
  localparam int LW = TW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] field,
  input  logic [1:0]    mult_code,
  output logic          expired
);
  import cfmw_pkg::*;

  logic [LW-1:0] scaled;
  logic [LW-1:0] span;
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    scaled = LW'(field) * LW'(mult_of(mult_code));
    span   = (scaled == '0) ? LW'(1) : scaled;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = span - LW'(1);
    else if (cnt_q != '0)  cnt_d = cnt_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/cfmw_rq_qual.sv
module cfmw_rq_qual #(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          dmarq,
  input  logic [QW-1:0] thresh,
  output logic          ok
);
  logic [QW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (!armed || !dmarq)  run_d = '0;
    else if (run_q != '1)  run_d = run_q + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign ok = armed && dmarq && (run_q >= thresh);

endmodule

// File: rtl/cfmw_byte_swap.sv
module cfmw_byte_swap #(
  parameter int DW = 16,
  localparam int LANES = DW / 16
) (
  input  logic          swap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*16 +: 16] = swap_en ? {din[g*16 +: 8], din[g*16+8 +: 8]}
                                      : din[g*16 +: 16];
  end

endmodule

// File: rtl/cf_mwdma_engine.sv
module cf_mwdma_engine #(
  parameter int AW = 32,
  parameter int SW = 20,
  parameter int TW = 6,
  parameter int QW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_en,
  input  logic          cfg_to_dev,
  input  logic          cfg_stop_on_drop,
  input  logic          cfg_swap,
  input  logic [SW-1:0] cfg_size,
  input  logic [AW-1:0] cfg_addr,
  input  logic          done_clr,
  input  logic          irq_en,
  input  logic [1:0]    tim_mult,
  input  logic [TW-1:0] rd_act,
  input  logic [TW-1:0] rd_neg,
  input  logic [TW-1:0] wr_act,
  input  logic [TW-1:0] wr_neg,
  input  logic [TW-1:0] ack_setup,
  input  logic [TW-1:0] ack_hold,
  input  logic [TW-1:0] pause_len,
  input  logic [QW-1:0] rq_qual,
  input  logic          ack_pol,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic [SW-1:0] size_rb,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dmarq,
  output logic          dmack,
  output logic          dior_n,
  output logic          diow_n,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  input  logic [DW-1:0] dd_in
);
  import cfmw_pkg::*;

  localparam logic [SW-1:0] SIZE_SPENT = '1;
  localparam logic [AW-1:0] ADDR_STEP  = AW'(DW / 8);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  cfmw_state_e   state_q, state_d;
  logic          en_q, en_d, dir_q, dir_d, stop_q, stop_d, swap_q, swap_d;
  logic          fin_q, fin_d, done_q, done_d, done_set;
  logic [SW-1:0] size_q, size_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] dd_q, dd_d;
  logic          tmr_load, tmr_exp, q_ok, enter_act, word_end, ack_int;
  logic [TW-1:0] tmr_field;
  logic [DW-1:0] mem_sw, dev_sw;

  cfmw_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_i), .load(tmr_load), .field(tmr_field),
    .mult_code(tim_mult), .expired(tmr_exp)
  );

  cfmw_rq_qual #(.QW(QW)) u_qual (
    .clk(clk), .rst_n(rst_i), .armed(state_q == ST_QUAL), .dmarq(dmarq),
    .thresh(rq_qual), .ok(q_ok)
  );

  cfmw_byte_swap #(.DW(DW)) u_swap_mem (.swap_en(swap_q), .din(mem_rdata), .dout(mem_sw));
  cfmw_byte_swap #(.DW(DW)) u_swap_dev (.swap_en(swap_q), .din(dd_in),     .dout(dev_sw));

  assign word_end = (state_q == ST_ACT) && tmr_exp;

  // next-state
  always_comb begin
    state_d  = state_q;
    en_d     = en_q;
    dir_d    = dir_q;
    stop_d   = stop_q;
    swap_d   = swap_q;
    size_d   = size_q;
    addr_d   = addr_q;
    fin_d    = fin_q;
    done_set = 1'b0;
    case (state_q)
      ST_QUAL:  if (q_ok) state_d = ST_SETUP;
      ST_SETUP: if (tmr_exp) state_d = ST_ACT;
      ST_ACT: if (tmr_exp) begin
        state_d = ST_NEG;
        size_d  = size_q - SW'(1);
        addr_d  = addr_q + ADDR_STEP;
      end
      ST_NEG: if (tmr_exp) begin
        if (size_q == SIZE_SPENT) begin
          state_d = ST_HOLD;
          fin_d   = 1'b1;
        end else if (dmarq) begin
          state_d = ST_ACT;
        end else begin
          state_d = ST_HOLD;
          fin_d   = stop_q;
        end
      end
      ST_HOLD: if (tmr_exp) begin
        if (fin_q) begin
          state_d  = ST_IDLE;
          en_d     = 1'b0;
          done_set = 1'b1;
        end else begin
          state_d  = ST_PAUSE;
        end
      end
      ST_PAUSE: if (tmr_exp) state_d = ST_QUAL;
      default: ;
    endcase
    if (cfg_wr) begin
      en_d    = cfg_en;
      dir_d   = cfg_to_dev;
      stop_d  = cfg_stop_on_drop;
      swap_d  = cfg_swap;
      size_d  = cfg_size;
      addr_d  = cfg_addr;
      fin_d   = 1'b0;
      state_d = cfg_en ? ST_QUAL : ST_IDLE;
    end
  end

  always_comb begin
    if (done_set)      done_d = 1'b1;
    else if (done_clr) done_d = 1'b0;
    else               done_d = done_q;
  end

  assign enter_act = (state_d == ST_ACT) && (state_q != ST_ACT);
  assign tmr_load  = (state_d != state_q);
  assign dd_d      = (enter_act && dir_q) ? mem_sw : dd_q;

  always_comb begin
    case (state_d)
      ST_SETUP: tmr_field = ack_setup;
      ST_ACT:   tmr_field = dir_q ? wr_act : rd_act;
      ST_NEG:   tmr_field = dir_q ? wr_neg : rd_neg;
      ST_HOLD:  tmr_field = ack_hold;
      ST_PAUSE: tmr_field = pause_len;
      default:  tmr_field = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      stop_q  <= 1'b0;
      swap_q  <= 1'b0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
      size_q  <= SIZE_SPENT;
      addr_q  <= '0;
      dd_q    <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      fin_q   <= fin_d;
      done_q  <= done_d;
      if (cfg_wr) begin
        dir_q  <= dir_d;
        stop_q <= stop_d;
        swap_q <= swap_d;
      end
      if (cfg_wr || word_end) begin
        size_q <= size_d;
        addr_q <= addr_d;
      end
      if (enter_act) dd_q <= dd_d;
    end
  end

  // outputs
  assign ack_int   = (state_q == ST_SETUP) || (state_q == ST_ACT) ||
                     (state_q == ST_NEG)   || (state_q == ST_HOLD);
  assign dmack     = ack_pol ? ack_int : !ack_int;
  assign dior_n    = !((state_q == ST_ACT) && !dir_q);
  assign diow_n    = !((state_q == ST_ACT) && dir_q);
  assign dd_oe     = dir_q && ((state_q == ST_ACT) || (state_q == ST_NEG));
  assign dd_out    = dd_q;
  assign mem_rd    = enter_act && dir_q;
  assign mem_wr    = word_end && !dir_q;
  assign mem_wdata = dev_sw;
  assign mem_addr  = addr_q;
  assign size_rb   = size_q;
  assign busy      = en_q;
  assign done      = done_q;
  assign irq       = done_q && irq_en;

endmodule

// File: rtl/cfmw_checker.sv
module cfmw_checker #(
  parameter int AW = 32,
  parameter int SW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          cfg_en,
  input logic [SW-1:0] cfg_size,
  input logic          irq_en,
  input logic          ack_pol,
  input logic          busy,
  input logic          done,
  input logic          irq,
  input logic [SW-1:0] size_rb,
  input logic [AW-1:0] mem_addr,
  input logic          dmack,
  input logic          dior_n,
  input logic          diow_n
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && irq_en)); // R4

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n)); // R5

  AST_STROBE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n || !diow_n) |-> (dmack == ack_pol)); // R12

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy); // R3

  AST_SIZE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(size_rb) && !$past(cfg_wr)) |-> (size_rb == $past(size_rb) - SW'(1))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mem_addr) && !$past(cfg_wr)) |-> (mem_addr == $past(mem_addr) + AW'(2))); // R6

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_en && (cfg_size == '1)) |=> (!busy && dior_n && diow_n && (dmack != ack_pol))); // R13

endmodule

bind cf_mwdma_engine cfmw_checker #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_size(cfg_size),
  .irq_en(irq_en), .ack_pol(ack_pol), .busy(busy), .done(done), .irq(irq),
  .size_rb(size_rb), .mem_addr(mem_addr), .dmack(dmack), .dior_n(dior_n), .diow_n(diow_n)
);

// File: tb/cf_mwdma_engine_test.sv
module cf_mwdma_engine_test;
  localparam logic [19:0] ALL1 = 20'hFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_en = 1'b0, cfg_to_dev = 1'b0, cfg_stop_on_drop = 1'b0, cfg_swap = 1'b0;
  logic [19:0] cfg_size = '0;
  logic [31:0] cfg_addr = '0;
  logic        done_clr = 1'b0, irq_en = 1'b0, ack_pol = 1'b0, dmarq = 1'b0;
  logic [1:0]  tim_mult = 2'd1;
  logic [5:0]  rd_act = 6'd2, rd_neg = 6'd2, wr_act = 6'd2, wr_neg = 6'd2;
  logic [5:0]  ack_setup = 6'd1, ack_hold = 6'd3, pause_len = 6'd2;
  logic [3:0]  rq_qual = 4'd1;
  logic        busy, done, irq, mem_rd, mem_wr, dmack, dior_n, diow_n, dd_oe;
  logic [19:0] size_rb;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, dd_out, dd_in;

  logic [15:0] mem [0:63];
  logic [15:0] dev_tx [0:63];
  logic [15:0] dev_rx [0:63];
  int rx_cnt = 0, strobes = 0, tx_idx = 0, run = 0, last_w = 0;
  logic w_prev = 1'b1, r_prev = 1'b1;
  int vectors = 0, miscompares = 0;

  always #5 clk = ~clk;

  cf_mwdma_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_to_dev(cfg_to_dev),
    .cfg_stop_on_drop(cfg_stop_on_drop), .cfg_swap(cfg_swap), .cfg_size(cfg_size),
    .cfg_addr(cfg_addr), .done_clr(done_clr), .irq_en(irq_en), .tim_mult(tim_mult),
    .rd_act(rd_act), .rd_neg(rd_neg), .wr_act(wr_act), .wr_neg(wr_neg),
    .ack_setup(ack_setup), .ack_hold(ack_hold), .pause_len(pause_len), .rq_qual(rq_qual),
    .ack_pol(ack_pol), .busy(busy), .done(done), .irq(irq), .size_rb(size_rb),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dmarq(dmarq), .dmack(dmack), .dior_n(dior_n), .diow_n(diow_n),
    .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in)
  );

  assign mem_rdata = mem[mem_addr[6:1]];
  assign dd_in     = dev_tx[tx_idx[5:0]];

  always @(posedge clk) if (mem_wr) mem[mem_addr[6:1]] <= mem_wdata;

  // card model and strobe monitor
  always @(negedge clk) begin
    if (!diow_n && w_prev) begin
      dev_rx[rx_cnt[5:0]] <= dd_out;
      rx_cnt <= rx_cnt + 1;
    end
    if ((!diow_n && w_prev) || (!dior_n && r_prev)) strobes <= strobes + 1;
    if (dior_n && !r_prev) tx_idx <= tx_idx + 1;
    if (!diow_n || !dior_n) run <= run + 1;
    else if (run != 0) begin
      last_w <= run;
      run <= 0;
    end
    w_prev <= diow_n;
    r_prev <= dior_n;
  end

  function automatic logic [15:0] bswap(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_cfg(input logic en, input logic td, input logic sd, input logic sw,
                        input logic [19:0] sz, input logic [31:0] ad);
    @(negedge clk);
    cfg_en = en; cfg_to_dev = td; cfg_stop_on_drop = sd; cfg_swap = sw;
    cfg_size = sz; cfg_addr = ad; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, tag, busy, 0);
  endtask

  task automatic pulse_clr;
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0 && irq == 0, "R1 done/irq", {done, irq}, 0);
    chk(dior_n && diow_n, "R1 strobes", {dior_n, diow_n}, 3);
    chk(dmack == 1'b1, "R1 dmack inactive", dmack, 1);
    chk(size_rb == ALL1, "R1 size", size_rb, ALL1);
  endtask

  task automatic t_write_basic;
    int base = rx_cnt;
    dmarq = 1'b1;
    do_cfg(1, 1, 0, 0, 20'd3, 32'h0000_0010);   // words at index 8..11
    wait_idle("R3 write finish");
    repeat (2) @(negedge clk);
    chk(rx_cnt - base == 4, "R2 words moved", rx_cnt - base, 4);
    for (int k = 0; k < 4; k++)
      chk(dev_rx[(base + k) % 64] == mem[8 + k], "R5 R6 write data", dev_rx[(base + k) % 64], mem[8 + k]);
    chk(size_rb == ALL1, "R2 size spent", size_rb, ALL1);
    chk(done == 1, "R3 done set", done, 1);
    chk(irq == 0, "R4 irq masked", irq, 0);
    pulse_clr();
    chk(done == 0, "R3 done cleared", done, 0);
  endtask

  task automatic t_read_swap;
    int base = tx_idx;
    irq_en = 1'b1;
    dmarq = 1'b1;
    do_cfg(1, 0, 0, 1, 20'd2, 32'h0000_0028);   // index 20..22
    wait_idle("R5 read finish");
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++)
      chk(mem[20 + k] == bswap(dev_tx[(base + k) % 64]), "R5 R7 read swapped",
          mem[20 + k], bswap(dev_tx[(base + k) % 64]));
    chk(irq == 1, "R4 irq raised", irq, 1);
    pulse_clr();
    chk(irq == 0, "R4 irq follows done", irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_write_swap;
    int base = rx_cnt;
    dmarq = 1'b1;
    do_cfg(1, 1, 0, 1, 20'd0, 32'h0000_0060);   // index 48
    wait_idle("R7 finish");
    repeat (2) @(negedge clk);
    chk(dev_rx[base % 64] == bswap(mem[48]), "R7 write swapped", dev_rx[base % 64], bswap(mem[48]));
    pulse_clr();
  endtask

  task automatic one_width(input logic [1:0] m, input logic [5:0] a, input int exp, input string tag);
    tim_mult = m; wr_act = a;
    dmarq = 1'b1;
    do_cfg(1, 1, 0, 0, 20'd0, 32'h0000_0050);
    wait_idle(tag);
    repeat (3) @(negedge clk);
    chk(last_w == exp, tag, last_w, exp);
    pulse_clr();
  endtask

  task automatic t_widths;
    one_width(2'd2, 6'd3, 6, "R10 x2 width");
    one_width(2'd0, 6'd2, 8, "R10 x4 width");
    one_width(2'd3, 6'd1, 8, "R10 x8 width");
    one_width(2'd1, 6'd0, 1, "R10 zero width");
    tim_mult = 2'd1; wr_act = 6'd2;
  endtask

  task automatic t_qual;
    bit seen = 0;
    int base = strobes;
    rq_qual = 4'd5;
    tim_mult = 2'd3;    // must not stretch the qualification
    dmarq = 1'b0;
    do_cfg(1, 1, 0, 0, 20'd0, 32'h0000_0000);
    dmarq = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (dmack == 1'b0) seen = 1;
    end
    dmarq = 1'b0;
    repeat (4) begin
      @(negedge clk);
      if (dmack == 1'b0) seen = 1;
    end
    chk(!seen, "R11 short request ignored", seen, 0);
    dmarq = 1'b1;
    repeat (6) @(negedge clk);
    chk(dmack == 1'b0, "R11 unscaled qualification", dmack, 0);
    wait_idle("R11 finish");
    repeat (2) @(negedge clk);
    chk(strobes - base == 1, "R11 one word", strobes - base, 1);
    pulse_clr();
    rq_qual = 4'd1; tim_mult = 2'd1;
  endtask

  task automatic t_pause;
    int base = strobes, rbase = rx_cnt, n = 0;
    bit ackd = 0;
    dmarq = 1'b1;
    do_cfg(1, 1, 0, 0, 20'd5, 32'h0000_0000);   // index 0..5
    while (strobes - base < 2 && n < 500) begin
      @(negedge clk);
      n++;
    end
    dmarq = 1'b0;
    repeat (20) @(negedge clk);
    repeat (10) begin
      @(negedge clk);
      if (dmack == 1'b0) ackd = 1;
    end
    chk(busy == 1, "R8 still busy", busy, 1);
    chk(!ackd, "R8 ack released", ackd, 0);
    chk(strobes - base == 2, "R8 no strobes while paused", strobes - base, 2);
    dmarq = 1'b1;
    wait_idle("R8 resume finish");
    repeat (2) @(negedge clk);
    chk(rx_cnt - rbase == 6, "R8 all words", rx_cnt - rbase, 6);
    for (int k = 0; k < 6; k++)
      chk(dev_rx[(rbase + k) % 64] == mem[k], "R8 data", dev_rx[(rbase + k) % 64], mem[k]);
    chk(size_rb == ALL1, "R8 size spent", size_rb, ALL1);
    pulse_clr();
  endtask

  task automatic t_terminate;
    int base = strobes, n = 0;
    dmarq = 1'b1;
    do_cfg(1, 1, 1, 0, 20'd5, 32'h0000_0000);
    while (strobes - base < 2 && n < 500) begin
      @(negedge clk);
      n++;
    end
    dmarq = 1'b0;
    wait_idle("R9 terminate");
    repeat (2) @(negedge clk);
    chk(strobes - base == 2, "R9 words before stop", strobes - base, 2);
    chk(done == 1, "R9 done", done, 1);
    chk(size_rb == 20'd3, "R9 remaining size", size_rb, 3);
    pulse_clr();
  endtask

  task automatic t_collide;
    int rises = 0, n = 0;
    logic prev;
    dmarq = 1'b1;
    do_cfg(1, 1, 0, 0, 20'd1, 32'h0000_0000);
    prev = diow_n;
    while (rises < 2 && n < 500) begin
      @(negedge clk);
      if (diow_n && !prev) rises++;
      prev = diow_n;
      n++;
    end
    // recovery 2 cycles plus hold 3 cycles after the last strobe edge
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(done == 0, "R3 done before collision", done, 0);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk(done == 1, "R3 set wins over clear", done, 1);
    chk(busy == 0, "R3 busy cleared", busy, 0);
    pulse_clr();
    chk(done == 0, "R3 clear after collision", done, 0);
  endtask

  task automatic t_polarity;
    int n = 0;
    ack_pol = 1'b1;
    @(negedge clk);
    chk(dmack == 1'b0, "R12 idle level high-active", dmack, 0);
    dmarq = 1'b1;
    do_cfg(1, 1, 0, 0, 20'd0, 32'h0000_0000);
    while (diow_n && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(dmack == 1'b1, "R12 active-high during strobe", dmack, 1);
    wait_idle("R12 finish");
    pulse_clr();
    ack_pol = 1'b0;
    @(negedge clk);
    chk(dmack == 1'b1, "R12 idle level low-active", dmack, 1);
  endtask

  task automatic t_stop;
    int n = 0;
    dmarq = 1'b0;
    do_cfg(1, 1, 0, 0, 20'd7, 32'h0000_0000);
    chk(busy == 1, "R13 armed", busy, 1);
    do_cfg(0, 1, 0, 0, ALL1, 32'h0000_0000);
    chk(busy == 0 && size_rb == ALL1, "R13 stop while waiting", {busy, size_rb}, {1'b0, ALL1});
    dmarq = 1'b1;
    do_cfg(1, 1, 0, 0, 20'd7, 32'h0000_0000);
    while (diow_n && n < 500) begin
      @(negedge clk);
      n++;
    end
    do_cfg(0, 1, 0, 0, ALL1, 32'h0000_0000);
    chk(busy == 0, "R13 stop mid transfer", busy, 0);
    chk(dior_n && diow_n && dmack == 1'b1, "R13 bus released", {dior_n, diow_n, dmack}, 7);
    chk(done == 0, "R13 no done", done, 0);
    repeat (10) @(negedge clk);
    chk(diow_n && size_rb == ALL1, "R13 stays idle", {diow_n, size_rb}, {1'b1, ALL1});
    dmarq = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]    = 16'(16'h1200 + i * 16'h0103);
      dev_tx[i] = 16'(16'hA05C + i * 16'h0111);
      dev_rx[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_basic();
    t_read_swap();
    t_write_swap();
    t_widths();
    t_qual();
    t_pause();
    t_terminate();
    t_collide();
    t_polarity();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule